// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the SCL waveform for an I2C master from the system clock. Each SCL period is a number of oversample ticks. A tick lasts a fixed number of system clocks. The period is split into a programmable low phase and a programmable high phase, and the low phase is normally the longer of the two.

The block pulls SCL low for the low phase and then releases the open-drain line. It does not start the high phase until the synchronized SCL input actually reads high. A slow rise, caused by a large pull-up or a heavy bus load, therefore stretches the real period: the real period is the programmed period plus the rise delay. A slave that holds SCL low is handled by the same wait. If the line never rises, the generator stalls. A programmable tick limit raises a stuck-bus flag while that wait lasts.

Two strobes guide the bit engine that drives SDA. The first strobe falls in the middle of the low phase and marks where SDA may change. The second falls on the first high cycle and marks where SDA is sampled.

Top module: `scl_clkgen`

## Requirements
- R1: Out of reset, and while `en` is low, `scl_drive_low`, `change_stb`, `sample_stb` and `stall_err` are all 0.
- R2: Each low phase drives `scl_drive_low` high for exactly `low_ticks * TICK_DIV` consecutive cycles.
- R3: After release, the high phase starts only once the input has passed the `SYNC_STAGES`-flop synchronizer. The synchronizer is held at 0 while the block drives low. Release lasts `SYNC_STAGES + 2 + d + high_ticks * TICK_DIV` cycles, where `d` is the number of cycles the bus takes to read high once the drive is gone.
- R4: Moving ticks between `low_ticks` and `high_ticks` with the same sum changes the duty cycle but leaves the total period unchanged.
- R5: While SCL is held low after release, the block stays released indefinitely, never drives low again and emits no `sample_stb`.
- R6: `stall_err` rises once SCL has been held low for `stall_ticks * TICK_DIV` cycles after release. It is 0 on the first high cycle after SCL finally rises. A `stall_ticks` of 0 disables it.
- R7: `change_stb` pulses for one cycle while driving low, at cycle `floor(low_ticks/2) * TICK_DIV` of the low phase (cycle 0 is the first low cycle).
- R8: `sample_stb` pulses exactly once per period, on the first cycle of the high phase, and only while SCL is released.
- R9: Deasserting `en` releases SCL and clears `stall_err` by the next cycle. Re-enabling starts a full-length low phase.
- R10: A tick count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run the generator; low returns it to idle with SCL released |
| low_ticks | input | CNT_W | Oversample ticks in the low phase |
| high_ticks | input | CNT_W | Oversample ticks in the high phase |
| stall_ticks | input | TMO_W | Ticks of held-low SCL before the stuck flag; 0 disables |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls the open-drain SCL line low |
| change_stb | output | 1 | Mid-low strobe: SDA may change |
| sample_stb | output | 1 | First-high strobe: SDA may be sampled |
| stall_err | output | 1 | SCL held low past the stall limit |

## Verification
The bench builds the block with `TICK_DIV = 2`, `SYNC_STAGES = 2`, `CNT_W = 6` and `TMO_W = 8`. A divider above one exposes the tick-to-cycle scaling in every phase length, the mid-low strobe position and the stall window. The bench drives SCL through a bus model with an adjustable rise delay and a slave hold. With it, the bench checks the extra release cycles that a slow rise adds, a stuck bus, the clearing of the stuck flag, and zero tick counts against values it works out itself.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_RISE = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;

endpackage

// File: rtl/scl_sync_chain.sv
module scl_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sr <= '0;
      else if (clr) sr <= '0;
      else          sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
   parameter int DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick,
   output logic first
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick  = 1'b1;
         assign first = 1'b1;
      end else begin : g_count
         localparam int DW = $clog2(DIV);
         localparam logic [DW-1:0] LAST = DW'(DIV - 1);
         logic [DW-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           div_q <= '0;
            else if (restart)     div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else                  div_q <= div_q + 1'b1;
         end

         assign tick  = (div_q == LAST);
         assign first = (div_q == '0);
      end
   endgenerate
endmodule

// File: rtl/scl_stall_watch.sv
module scl_stall_watch #(
   parameter int TMO_W  = 8,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic [TMO_W-1:0] limit,
   output logic             err
);
   generate
      if (ENABLE) begin : g_watch
         logic [TMO_W-1:0] cnt;
         logic             err_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt   <= '0;
               err_q <= 1'b0;
            end else if (!active) begin
               cnt   <= '0;
               err_q <= 1'b0;
            end else if (tick && (limit != '0) && !err_q) begin
               if (cnt == limit - 1'b1) err_q <= 1'b1;
               else                     cnt   <= cnt + 1'b1;
            end
         end

         assign err = err_q;
      end else begin : g_none
         assign err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
   parameter int CNT_W       = 8,
   parameter int TMO_W       = 16,
   parameter int TICK_DIV    = 1,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_STALL   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] low_ticks,
   input  logic [CNT_W-1:0] high_ticks,
   input  logic [TMO_W-1:0] stall_ticks,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             change_stb,
   output logic             sample_stb,
   output logic             stall_err
);
   import scl_clkgen_pkg::*;

   generate
      if (CNT_W < 2)       begin : g_bad_cnt  $error("CNT_W must be at least 2");       end
      if (TMO_W < 1)       begin : g_bad_tmo  $error("TMO_W must be at least 1");       end
      if (TICK_DIV < 1)    begin : g_bad_div  $error("TICK_DIV must be at least 1");    end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   scl_phase_e       phase_q, phase_d;
   logic [CNT_W-1:0] pc_q;
   logic [CNT_W-1:0] low_last, high_last, low_mid;
   logic             scl_s, tick, tick_first, restart;

   // a zero count behaves as a one-tick phase
   assign low_last  = (low_ticks  == '0) ? '0 : low_ticks  - 1'b1;
   assign high_last = (high_ticks == '0) ? '0 : high_ticks - 1'b1;
   assign low_mid   = low_ticks >> 1;

   scl_sync_chain #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_q == PH_LOW),
      .d     (scl_in),
      .q     (scl_s)
   );

   scl_tick_div #(.DIV(TICK_DIV)) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick),
      .first   (tick_first)
   );

   scl_stall_watch #(.TMO_W(TMO_W), .ENABLE(HAS_STALL)) i_stall (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (en && (phase_q == PH_RISE) && !scl_s),
      .tick   (tick),
      .limit  (stall_ticks),
      .err    (stall_err)
   );

   always_comb begin
      phase_d = phase_q;
      if (!en) begin
         phase_d = PH_IDLE;
      end else begin
         unique case (phase_q)
            PH_IDLE: phase_d = PH_LOW;
            PH_LOW:  if (tick && pc_q == low_last)  phase_d = PH_RISE;
            PH_RISE: if (scl_s)                      phase_d = PH_HIGH;
            PH_HIGH: if (tick && pc_q == high_last) phase_d = PH_LOW;
            default: phase_d = PH_IDLE;
         endcase
      end
   end

   assign restart = (phase_d != phase_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pc_q    <= '0;
      end else begin
         phase_q <= phase_d;
         if (restart)   pc_q <= '0;
         else if (tick) pc_q <= pc_q + 1'b1;
      end
   end

   assign scl_drive_low = (phase_q == PH_LOW);
   assign change_stb    = (phase_q == PH_LOW)  && (pc_q == low_mid) && tick_first;
   assign sample_stb    = (phase_q == PH_HIGH) && (pc_q == '0)      && tick_first;
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic scl_in,
   input logic scl_drive_low,
   input logic change_stb,
   input logic sample_stb,
   input logic stall_err
);
   // R7: the data-change strobe only falls inside the driven low phase
   p_change_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      change_stb |-> scl_drive_low);

   // R8: the sample strobe only appears with SCL released
   p_sample_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> !scl_drive_low);

   // R8: the two strobes never coincide
   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(change_stb && sample_stb));

   // R9: disable releases the line and clears the stuck flag next cycle
   p_disable_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!scl_drive_low && !stall_err));

   // R6: the stuck flag is only raised while the line is released
   p_err_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stall_err |-> !scl_drive_low);

   // R5: a line seen low for two cycles cannot yield a sample strobe
   p_no_sample_when_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_drive_low && !scl_in) |=> (!scl_in |=> !sample_stb));
endmodule

bind scl_clkgen scl_clkgen_chk i_scl_clkgen_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en            (en),
   .scl_in        (scl_in),
   .scl_drive_low (scl_drive_low),
   .change_stb    (change_stb),
   .sample_stb    (sample_stb),
   .stall_err     (stall_err)
);

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
   localparam int CNT_W = 6;
   localparam int TMO_W = 8;
   localparam int DIV   = 2;
   localparam int SYNC  = 2;
   localparam int REL0  = SYNC + 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [CNT_W-1:0] low_ticks = 6'd11;
   logic [CNT_W-1:0] high_ticks = 6'd9;
   logic [TMO_W-1:0] stall_ticks = '0;
   logic             scl_line = 1'b1;
   logic             scl_drive_low, change_stb, sample_stb, stall_err;

   int rise_dly = 0;
   logic hold = 1'b0;
   int rcnt = 0;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   // open-drain bus: falls after a driven low or a hold, rises rise_dly cycles later
   always @(posedge clk) begin
      if (scl_drive_low || hold) begin
         rcnt     <= 0;
         scl_line <= 1'b0;
      end else if (rcnt >= rise_dly) begin
         scl_line <= 1'b1;
      end else begin
         rcnt <= rcnt + 1;
      end
   end

   scl_clkgen #(.CNT_W(CNT_W), .TMO_W(TMO_W), .TICK_DIV(DIV),
                .SYNC_STAGES(SYNC), .HAS_STALL(1'b1)) i_scl_clkgen (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .low_ticks     (low_ticks),
      .high_ticks    (high_ticks),
      .stall_ticks   (stall_ticks),
      .scl_in        (scl_line),
      .scl_drive_low (scl_drive_low),
      .change_stb    (change_stb),
      .sample_stb    (sample_stb),
      .stall_err     (stall_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one full period from a driven-low start to the next
   task automatic measure(output int lo, output int hi, output int chg,
                          output int smp, output int nsmp);
      lo = 0; hi = 0; chg = -1; smp = -1; nsmp = 0;
      @(negedge clk);
      while (scl_drive_low) @(negedge clk);
      while (!scl_drive_low) @(negedge clk);
      while (scl_drive_low) begin
         if (change_stb) chg = lo;
         lo++;
         @(negedge clk);
      end
      while (!scl_drive_low) begin
         if (sample_stb) begin
            smp = hi;
            nsmp++;
         end
         hi++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 drive in reset", int'(scl_drive_low), 0);
      chk("R1 strobes in reset", int'(change_stb | sample_stb | stall_err), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 idle while disabled", int'(scl_drive_low | change_stb | sample_stb | stall_err), 0);
   endtask

   task automatic t_basic();
      int lo, hi, chg, smp, nsmp;
      low_ticks = 11; high_ticks = 9; rise_dly = 0;
      en = 1'b1;
      measure(lo, hi, chg, smp, nsmp);
      chk("R2 low length", lo, 11 * DIV);
      chk("R3 release length", hi, REL0 + 9 * DIV);
      chk("R7 change index", chg, 5 * DIV);
      chk("R8 sample index", smp, REL0);
      chk("R8 sample count", nsmp, 1);
   endtask

   task automatic t_slow_rise();
      int lo, hi, chg, smp, nsmp;
      rise_dly = 5;
      measure(lo, hi, chg, smp, nsmp);
      chk("R3 slow rise release", hi, REL0 + 5 + 9 * DIV);
      chk("R3 slow rise sample", smp, REL0 + 5);
      chk("R2 low unchanged", lo, 11 * DIV);
      rise_dly = 0;
   endtask

   task automatic t_duty();
      int lo, hi, chg, smp, nsmp;
      low_ticks = 13; high_ticks = 7;
      measure(lo, hi, chg, smp, nsmp);
      chk("R4 period", lo + hi, 20 * DIV + REL0);
      chk("R4 low share", lo, 13 * DIV);
      chk("R7 change odd", chg, 6 * DIV);
      low_ticks = 11; high_ticks = 9;
      measure(lo, hi, chg, smp, nsmp);
   endtask

   task automatic t_stretch();
      int idx, bad, lo, hi, chg, smp, nsmp;
      stall_ticks = 6;
      @(negedge clk);
      while (!scl_drive_low) @(negedge clk);
      hold = 1'b1;
      while (scl_drive_low) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 100; i++) begin
         idx = i;
         if (idx == 6 * DIV - 2) chk("R6 err not yet", int'(stall_err), 0);
         if (idx == 6 * DIV + 1) chk("R6 err raised", int'(stall_err), 1);
         if (scl_drive_low || sample_stb) bad++;
         @(negedge clk);
      end
      chk("R5 held stays released", bad, 0);
      hold = 1'b0;
      while (!sample_stb) @(negedge clk);
      chk("R6 err cleared on rise", int'(stall_err), 0);
      stall_ticks = 0;
      measure(lo, hi, chg, smp, nsmp);
      chk("R5 resumes", hi, REL0 + 9 * DIV);
   endtask

   task automatic t_no_limit();
      int seen;
      stall_ticks = 0;
      @(negedge clk);
      while (!scl_drive_low) @(negedge clk);
      hold = 1'b1;
      while (scl_drive_low) @(negedge clk);
      seen = 0;
      for (int i = 0; i < 60; i++) begin
         if (stall_err) seen++;
         @(negedge clk);
      end
      chk("R6 limit zero disables", seen, 0);
      hold = 1'b0;
   endtask

   task automatic t_disable();
      int bad, lo, hi, chg, smp, nsmp;
      @(negedge clk);
      while (!scl_drive_low) @(negedge clk);
      repeat (4) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk("R9 release after disable", int'(scl_drive_low), 0);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         if (scl_drive_low || change_stb || sample_stb || stall_err) bad++;
         @(negedge clk);
      end
      chk("R1 disabled quiet", bad, 0);
      en = 1'b1;
      @(negedge clk);
      lo = 0;
      while (scl_drive_low) begin
         lo++;
         @(negedge clk);
      end
      chk("R9 full low after enable", lo, 11 * DIV);
      measure(lo, hi, chg, smp, nsmp);
   endtask

   task automatic t_zero();
      int lo, hi, chg, smp, nsmp;
      low_ticks = 0; high_ticks = 0;
      measure(lo, hi, chg, smp, nsmp);
      measure(lo, hi, chg, smp, nsmp);
      chk("R10 zero low", lo, DIV);
      chk("R10 zero high", hi, REL0 + DIV);
      chk("R10 zero change", chg, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_slow_rise();
      t_duty();
      t_stretch();
      t_no_limit();
      t_disable();
      t_zero();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule